// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Detector

This block watches eighteen general-purpose input pins and reports any change of level, rising or falling, through three group interrupt flags. The pins are divided unevenly: the lowest eight pins form group 0, the next three form group 1, and the top seven form group 2. Each group has its own mask register, and only the pins whose mask bit is set can raise that group's flag. Detection works on the pin level itself, so firmware that drives a pin as an output can raise an interrupt by toggling it.

Every pin passes through a capture register, a synchroniser register and a history register. The XOR of the last two gives a one-cycle toggle pulse. For each group the masked toggles are OR-reduced into a registered set pulse, and that pulse sets the group flag one clock later. Flags are cleared by writing a one to them. A request output is raised for each group whose flag and enable bit are both high.

Top module: `pinchg_irq`

## Requirements
- R1: Pins 0 to 7 belong to group 0, pins 8 to 10 belong to group 1, and pins 11 to 17 belong to group 2. A toggle sets only the flag of the group that owns the pin, in the flag bit with the same index as the group.
- R2: A rising transition and a falling transition on an enabled pin both set the group flag.
- R3: Pulsing `mask_we_i[g]` loads the low bits of `mask_wdata_i` into the mask of group g. Bit j of that mask enables the group's j-th pin, counted from the group's lowest pin. All masks reset to zero. A toggle on a pin whose mask bit is zero leaves the flag unchanged.
- R4: Suppose a new pin level is first sampled at rising edge k. The flag then rises at edge k+3 and is visible after that edge. It stays low after edges k, k+1 and k+2.
- R5: When `flag_clr_i[g]` is high at an edge, flag g is cleared. If the set pulse of the same group is active at that edge, the flag is set instead.
- R6: `irq_o[g]` is high exactly when flag g is high and `irq_en_i[g]` is high.
- R7: Writing a mask while the pins are steady never sets a flag.
- R8: A synchronous active-high reset clears every flag, every mask and every set pulse. It loads the pipeline with the current pin levels, so non-zero pins held across reset produce no flag afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 18 | Raw pin levels |
| mask_we_i | input | 3 | Per-group mask write strobe |
| mask_wdata_i | input | 8 | Mask write data, low bits used per group |
| flag_clr_i | input | 3 | Write-one-to-clear strobe per flag |
| irq_en_i | input | 3 | Per-group request enable |
| flag_o | output | 3 | Group interrupt flags |
| irq_o | output | 3 | Group interrupt requests |

## Verification
A corrupted capture, synchroniser or history bit appears on `flag_o` as a spurious or missing flag three edges after the faulty sample. Because of this, the reference model's comparison on every cycle catches it within four clocks. A wrong mask shows as a flag that rises for an excluded pin, or fails to rise for an included one, in the same three-edge window. A wrong set-over-clear order or a misrouted group bit differs from the model on the first cycle after the edge in question, and `irq_o` carries any flag error forward at once.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;

    localparam int NPIN  = 18;
    localparam int NGRP  = 3;
    localparam int MASKW = 8;

    // lowest pin index owned by a group
    function automatic int grp_lo(input int g);
        case (g)
            0:       return 0;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    // number of pins owned by a group
    function automatic int grp_w(input int g);
        case (g)
            0:       return 8;
            1:       return 3;
            default: return 7;
        endcase
    endfunction

    typedef struct packed {
        logic [NPIN-1:0] cap;
        logic [NPIN-1:0] syn;
        logic [NPIN-1:0] hist;
    } pin_pipe_t;

    typedef struct packed {
        logic set_q;
        logic flag_q;
    } grp_state_t;

endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync
    import pinchg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] toggle_o
);

    pin_pipe_t pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            // preload every stage with the live pins: no edge after reset
            pipe_q.cap  <= pin_i;
            pipe_q.syn  <= pin_i;
            pipe_q.hist <= pin_i;
        end else begin
            pipe_q.cap  <= pin_i;
            pipe_q.syn  <= pipe_q.cap;
            pipe_q.hist <= pipe_q.syn;
        end
    end

    assign toggle_o = pipe_q.syn ^ pipe_q.hist;

endmodule

// File: rtl/pinchg_group.sv
module pinchg_group
    import pinchg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] toggle_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    input  logic         clr_i,
    input  logic         en_i,
    output logic         set_o,
    output logic         flag_o,
    output logic         irq_o
);

    logic [W-1:0] mask_q;
    grp_state_t   st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.set_q  <= |(toggle_i & mask_q);
            // a set pulse takes precedence over a clear in the same cycle
            st_q.flag_q <= (st_q.flag_q & ~clr_i) | st_q.set_q;
        end
    end

    assign set_o  = st_q.set_q;
    assign flag_o = st_q.flag_q;
    assign irq_o  = st_q.flag_q & en_i;

endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq
    import pinchg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  pin_in,
    input  logic [NGRP-1:0]  mask_we_i,
    input  logic [MASKW-1:0] mask_wdata_i,
    input  logic [NGRP-1:0]  flag_clr_i,
    input  logic [NGRP-1:0]  irq_en_i,
    output logic [NGRP-1:0]  flag_o,
    output logic [NGRP-1:0]  irq_o
);

    logic [NPIN-1:0] toggle;
    logic [NGRP-1:0] set_pulse;

    pinchg_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (pin_in),
        .toggle_o (toggle)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = grp_lo(g);
        localparam int W  = grp_w(g);

        pinchg_group #(.W(W)) u_grp (
            .clk          (clk),
            .rst          (rst),
            .toggle_i     (toggle[LO +: W]),
            .mask_we_i    (mask_we_i[g]),
            .mask_wdata_i (mask_wdata_i[W-1:0]),
            .clr_i        (flag_clr_i[g]),
            .en_i         (irq_en_i[g]),
            .set_o        (set_pulse[g]),
            .flag_o       (flag_o[g]),
            .irq_o        (irq_o[g])
        );
    end

endmodule

// File: rtl/pinchg_chk.sv
module pinchg_chk
    import pinchg_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NGRP-1:0] flag_o,
    input logic [NGRP-1:0] flag_clr_i,
    input logic [NGRP-1:0] set_pulse,
    input logic [NGRP-1:0] irq_o,
    input logic [NGRP-1:0] irq_en_i
);

    // R8: the edge after reset leaves no flag and no pending set
    a_r8_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (flag_o == '0 && set_pulse == '0));

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        // R5: a set pulse always lands in the flag, even against a clear
        a_r5_set_lands: assert property (@(posedge clk) disable iff (rst)
            set_pulse[g] |=> flag_o[g]);

        // R5: a clear with no competing set empties the flag
        a_r5_clear_works: assert property (@(posedge clk) disable iff (rst)
            (flag_clr_i[g] && !set_pulse[g]) |=> !flag_o[g]);

        // R4: a flag only rises after its set pulse
        a_r4_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_o[g]) |-> $past(set_pulse[g]));

        // R5: a flag only falls after a clear write
        a_r5_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
            $fell(flag_o[g]) |-> $past(flag_clr_i[g]));

        // R6: a request needs both flag and enable
        a_r6_req_gated: assert property (@(posedge clk) disable iff (rst)
            irq_o[g] |-> (flag_o[g] && irq_en_i[g]));
    end

endmodule

bind pinchg_irq pinchg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .flag_o     (flag_o),
    .flag_clr_i (flag_clr_i),
    .set_pulse  (set_pulse),
    .irq_o      (irq_o),
    .irq_en_i   (irq_en_i)
);

// File: tb/sim_pinchg_irq.sv
`timescale 1ns/1ps
module sim_pinchg_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] pin_in = 18'h2A5A5;
    logic [2:0]  mask_we_i = '0;
    logic [7:0]  mask_wdata_i = '0;
    logic [2:0]  flag_clr_i = '0;
    logic [2:0]  irq_en_i = '0;
    logic [2:0]  flag_o;
    logic [2:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R8";

    always #10 clk = ~clk;

    pinchg_irq u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .mask_we_i(mask_we_i),
        .mask_wdata_i(mask_wdata_i), .flag_clr_i(flag_clr_i),
        .irq_en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    logic [17:0] samp[$];
    logic [7:0]  m_mask[3];
    logic [2:0]  m_set, m_flag;

    function automatic int base_of(int g);
        return (g == 0) ? 0 : (g == 1) ? 8 : 11;
    endfunction
    function automatic int grp_of(int i);
        return (i < 8) ? 0 : (i < 11) ? 1 : 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            samp = '{pin_in, pin_in, pin_in};
            for (int g = 0; g < 3; g++) m_mask[g] = '0;
            m_set = '0;
            m_flag = '0;
        end else begin
            logic [17:0] tg;
            logic [2:0]  ns;
            tg = samp[1] ^ samp[2];
            ns = '0;
            for (int i = 0; i < 18; i++)
                if (tg[i] && m_mask[grp_of(i)][i - base_of(grp_of(i))])
                    ns[grp_of(i)] = 1'b1;
            m_flag = (m_flag & ~flag_clr_i) | m_set;
            m_set = ns;
            for (int g = 0; g < 3; g++)
                if (mask_we_i[g]) m_mask[g] = mask_wdata_i;
            samp.push_front(pin_in);
            void'(samp.pop_back());
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, {irq_o, flag_o}, {m_flag & irq_en_i, m_flag});
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_all();
        flag_clr_i = 3'b111;
        step();
        flag_clr_i = '0;
        step();
    endtask

    task automatic wr_mask(logic [2:0] we, logic [7:0] d);
        mask_we_i = we;
        mask_wdata_i = d;
        step();
        mask_we_i = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset with non-zero pins, no flag afterwards
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R8";
        chk("R8", {irq_o, flag_o}, 6'b0);
        steps(6);
        chk("R8", {3'b0, flag_o}, 6'b0);

        // R7: mask writes on steady pins
        cur_req = "R7";
        wr_mask(3'b111, 8'hFF);
        wr_mask(3'b010, 8'h05);
        wr_mask(3'b111, 8'hFF);
        steps(5);
        chk("R7", {3'b0, flag_o}, 6'b0);

        irq_en_i = 3'b111;

        // R4 + R2: rising edge on pin 3, exact latency
        cur_req = "R4";
        pin_in[3] = ~pin_in[3];
        step(); chk("R4", {5'b0, flag_o[0]}, 6'd0);
        step(); chk("R4", {5'b0, flag_o[0]}, 6'd0);
        step(); chk("R4", {5'b0, flag_o[0]}, 6'd0);
        step(); chk("R4", {3'b0, flag_o}, 6'b000001);
        chk("R6", {3'b0, irq_o}, 6'b000001);

        // R5: clear the flag
        cur_req = "R5";
        flag_clr_i = 3'b001;
        step();
        flag_clr_i = '0;
        chk("R5", {3'b0, flag_o}, 6'b0);

        // R2: the opposite transition on the same pin
        cur_req = "R2";
        pin_in[3] = ~pin_in[3];
        steps(5);
        chk("R2", {3'b0, flag_o}, 6'b000001);
        clear_all();

        // R1: group routing
        cur_req = "R1";
        pin_in[9] = ~pin_in[9];
        steps(5);
        chk("R1", {3'b0, flag_o}, 6'b000010);
        clear_all();
        pin_in[15] = ~pin_in[15];
        steps(5);
        chk("R1", {3'b0, flag_o}, 6'b000100);
        clear_all();
        pin_in[7] = ~pin_in[7];
        pin_in[11] = ~pin_in[11];
        steps(5);
        chk("R1", {3'b0, flag_o}, 6'b000101);
        clear_all();

        // R3: group 2 sees only pin 11
        cur_req = "R3";
        wr_mask(3'b100, 8'h01);
        pin_in[15] = ~pin_in[15];
        steps(5);
        chk("R3", {3'b0, flag_o}, 6'b0);
        pin_in[11] = ~pin_in[11];
        steps(5);
        chk("R3", {3'b0, flag_o}, 6'b000100);
        clear_all();
        wr_mask(3'b100, 8'h7F);

        // R5: set wins over a simultaneous clear
        cur_req = "R5";
        pin_in[0] = ~pin_in[0];
        steps(5);
        pin_in[0] = ~pin_in[0];
        steps(3);
        flag_clr_i = 3'b001;
        step();
        flag_clr_i = '0;
        chk("R5", {5'b0, flag_o[0]}, 6'd1);
        clear_all();

        // R6: enable gates the request only
        cur_req = "R6";
        irq_en_i = 3'b101;
        pin_in[8] = ~pin_in[8];
        steps(5);
        chk("R6", {irq_o, flag_o}, 6'b000_010);
        clear_all();

        // mixed stimulus against the model
        cur_req = "R1";
        for (int n = 0; n < 2000; n++) begin
            pin_in = pin_in ^ (($urandom % 4 == 0) ? 18'($urandom) : 18'h0);
            flag_clr_i = ($urandom % 5 == 0) ? 3'($urandom) : 3'b0;
            irq_en_i = 3'($urandom);
            if ($urandom % 10 == 0) begin
                mask_we_i = 3'($urandom);
                mask_wdata_i = 8'($urandom);
            end else begin
                mask_we_i = '0;
            end
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule